// File: doc/BRIEF.md
# USB Suspend and Missed-SOF Timer

This block watches the start-of-frame stream and general bus traffic of a full-speed USB device. A free-running window, measured in ticks of an external millisecond-scale strobe, expects one SOF per millisecond. Each window that closes without an SOF raises a missed-frame flag. A run of consecutive misses with no traffic between them raises a suspend request. A received SOF, any bus activity or a bus reset breaks the run.

The suspend check is armed by a detected bus reset or by the end of a resume sequence. It is disarmed while the suspend-active level is high, and it stays disarmed after that level falls until a resume-done pulse arrives. While suspend is active, bus activity raises a wakeup flag and a one-cycle wakeup strobe. Four sticky flags (frame seen, frame missed, suspend request, wakeup) hold until software writes 0 to them.

Top module: `usb_susp_timer`

## Requirements
- R1: After `rst_n` is released, all four flags, `wakeup_o` and `locked_o` are 0, and the suspend check is disarmed.
- R2: An `sof_rx_i` pulse sets `flag_sof_o` from the next cycle on. The first such pulse after reset sets `locked_o`, which then stays 1 until `rst_n`.
- R3: A missed frame is detected on the cycle of the TICKS_PER_MS-th `ms_tick_i` pulse since the last SOF, bus reset or power reset. This holds whether or not the block is locked. It sets `flag_esof_o` on the next cycle and starts a new window.
- R4: An SOF restarts the window, so TICKS_PER_MS-1 ticks after an SOF produce no missed frame.
- R5: While the check is disarmed, missed frames never set `flag_susp_o`. After power reset the check stays disarmed until a `bus_reset_i` pulse.
- R6: With the check armed, MISS_LIMIT consecutive missed frames set `flag_susp_o` on the cycle after the last one.
- R7: `bus_act_i`, `sof_rx_i` or `bus_reset_i` clears the run of missed frames. Activity in the same cycle as a miss cancels that miss.
- R8: `susp_active_i` high disarms the check. After it falls, the check stays disarmed until `resume_done_i` (or `bus_reset_i`) arrives.
- R9: `bus_act_i` while `susp_active_i` is high sets `flag_wkup_o` and drives `wakeup_o` high for the following cycle. With `susp_active_i` low, activity does neither.
- R10: A cycle with `flag_wr_i` high clears each flag whose `flag_wdata_i` bit is 0 and leaves the others unchanged. The bit positions are: sof bit 0, esof bit 1, susp bit 2, wkup bit 3.
- R11: A flag event in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | Timing strobe; TICKS_PER_MS pulses make one frame window |
| sof_rx_i | input | 1 | Start-of-frame received pulse |
| bus_act_i | input | 1 | Bus traffic detected pulse |
| bus_reset_i | input | 1 | USB bus reset detected pulse |
| susp_active_i | input | 1 | Suspend mode active level |
| resume_done_i | input | 1 | Resume sequence finished pulse |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 4 | Write data; a 0 bit clears the matching flag |
| flag_sof_o | output | 1 | Sticky frame-received flag |
| flag_esof_o | output | 1 | Sticky missed-frame flag |
| flag_susp_o | output | 1 | Sticky suspend-request flag |
| flag_wkup_o | output | 1 | Sticky wakeup flag |
| wakeup_o | output | 1 | One-cycle wakeup strobe |
| locked_o | output | 1 | An SOF has been seen since reset |

## Verification
A window counter that drifts appears on `flag_esof_o` one tick early or late, within the first window after an SOF. A miss counter that fails to clear, or an arm state that leaks across suspend, appears as `flag_susp_o` rising or staying low one frame away from the expected window. Every output is compared with an independent cycle model on every cycle, so such a fault is reported on the cycle it reaches a port.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
   localparam int FLAG_CNT = 4;
   localparam int FL_SOF  = 0;
   localparam int FL_ESOF = 1;
   localparam int FL_SUSP = 2;
   localparam int FL_WKUP = 3;
   typedef logic [FLAG_CNT-1:0] flag_vec_t;
endpackage

// File: rtl/usb_frame_window.sv
module usb_frame_window #(
   parameter int TICKS_PER_MS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic sof_i,
   input  logic busrst_i,
   output logic esof_o,
   output logic locked_o
);
   localparam int WIN_W = (TICKS_PER_MS > 2) ? $clog2(TICKS_PER_MS) : 1;
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(TICKS_PER_MS - 1);

   initial begin
      if (TICKS_PER_MS < 2) $error("TICKS_PER_MS must be at least 2");
   end

   logic [WIN_W-1:0] win_q;
   logic             lock_q;

   assign esof_o   = tick_i && !sof_i && !busrst_i && (win_q == WIN_LAST);
   assign locked_o = lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         if (sof_i) lock_q <= 1'b1;
         if (busrst_i || sof_i)  win_q <= '0;
         else if (esof_o)        win_q <= '0;
         else if (tick_i)        win_q <= win_q + 1'b1;
      end
   end

   assert_sof_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sof_i |=> !esof_o);
   assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> locked_o);
endmodule

// File: rtl/usb_idle_monitor.sv
module usb_idle_monitor #(
   parameter int MISS_LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic esof_i,
   input  logic sof_i,
   input  logic act_i,
   input  logic busrst_i,
   input  logic susp_active_i,
   input  logic resume_done_i,
   output logic susp_evt_o,
   output logic wkup_evt_o
);
   localparam int MISS_W = (MISS_LIMIT > 2) ? $clog2(MISS_LIMIT) : 1;
   localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

   initial begin
      if (MISS_LIMIT < 2) $error("MISS_LIMIT must be at least 2");
   end

   logic [MISS_W-1:0] miss_q;
   logic              armed_q;
   logic              gate;
   logic              run_break;

   assign gate       = armed_q && !susp_active_i;
   assign run_break  = !gate || busrst_i || sof_i || act_i;
   assign susp_evt_o = !run_break && esof_i && (miss_q == MISS_LAST);
   assign wkup_evt_o = susp_active_i && act_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         if (susp_active_i)                  armed_q <= 1'b0;
         else if (busrst_i || resume_done_i) armed_q <= 1'b1;

         if (run_break || susp_evt_o) miss_q <= '0;
         else if (esof_i)             miss_q <= miss_q + 1'b1;
      end
   end

   assert_miss_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q <= MISS_LAST);
   assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      susp_active_i |=> !armed_q);
   assert_activity_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> (miss_q == '0));
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         wr_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] flags_o
);
   initial begin
      if (N < 1) $error("flag bank needs at least one flag");
   end

   for (genvar g = 0; g < N; g++) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               bit_q <= 1'b0;
         else if (set_i[g])        bit_q <= 1'b1;
         else if (wr_i && !wdata_i[g]) bit_q <= 1'b0;
      end
      assign flags_o[g] = bit_q;

      assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> flags_o[g]);
      assert_keep_on_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_o[g] && wr_i && wdata_i[g]) |=> flags_o[g]);
   end
endmodule

// File: rtl/usb_susp_timer.sv
module usb_susp_timer
   import usb_susp_pkg::*;
#(
   parameter int TICKS_PER_MS = 1000,
   parameter int MISS_LIMIT   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ms_tick_i,
   input  logic                sof_rx_i,
   input  logic                bus_act_i,
   input  logic                bus_reset_i,
   input  logic                susp_active_i,
   input  logic                resume_done_i,
   input  logic                flag_wr_i,
   input  logic [FLAG_CNT-1:0] flag_wdata_i,
   output logic                flag_sof_o,
   output logic                flag_esof_o,
   output logic                flag_susp_o,
   output logic                flag_wkup_o,
   output logic                wakeup_o,
   output logic                locked_o
);
   logic      esof_evt;
   logic      susp_evt;
   logic      wkup_evt;
   logic      wake_q;
   flag_vec_t set_vec;
   flag_vec_t flags;

   usb_frame_window #(.TICKS_PER_MS(TICKS_PER_MS)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (ms_tick_i),
      .sof_i    (sof_rx_i),
      .busrst_i (bus_reset_i),
      .esof_o   (esof_evt),
      .locked_o (locked_o)
   );

   usb_idle_monitor #(.MISS_LIMIT(MISS_LIMIT)) u_idle (
      .clk           (clk),
      .rst_n         (rst_n),
      .esof_i        (esof_evt),
      .sof_i         (sof_rx_i),
      .act_i         (bus_act_i),
      .busrst_i      (bus_reset_i),
      .susp_active_i (susp_active_i),
      .resume_done_i (resume_done_i),
      .susp_evt_o    (susp_evt),
      .wkup_evt_o    (wkup_evt)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[FL_SOF]  = sof_rx_i;
      set_vec[FL_ESOF] = esof_evt;
      set_vec[FL_SUSP] = susp_evt;
      set_vec[FL_WKUP] = wkup_evt;
   end

   usb_flag_bank #(.N(FLAG_CNT)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .wr_i    (flag_wr_i),
      .wdata_i (flag_wdata_i),
      .flags_o (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= wkup_evt;
   end

   assign wakeup_o    = wake_q;
   assign flag_sof_o  = flags[FL_SOF];
   assign flag_esof_o = flags[FL_ESOF];
   assign flag_susp_o = flags[FL_SUSP];
   assign flag_wkup_o = flags[FL_WKUP];

   assert_wake_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_active_i && bus_act_i) |=> (wakeup_o && flag_wkup_o));
   assert_no_wake_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !susp_active_i |=> !wakeup_o);
endmodule

// File: tb/usb_susp_timer_tb.sv
module usb_susp_timer_tb;
   localparam int T = 4;
   localparam int M = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 0, sof = 0, act = 0, brst = 0, sact = 0, rdone = 0, wr = 0;
   logic [3:0] wd = 4'hF;
   logic f_sof, f_esof, f_susp, f_wkup, wake, lock;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int   m_win, m_miss;
   logic m_arm, m_lock, m_wake;
   logic [3:0] m_flags;

   always #10 clk = ~clk;

   usb_susp_timer #(.TICKS_PER_MS(T), .MISS_LIMIT(M)) u_dut (
      .clk(clk), .rst_n(rst_n), .ms_tick_i(tick), .sof_rx_i(sof),
      .bus_act_i(act), .bus_reset_i(brst), .susp_active_i(sact),
      .resume_done_i(rdone), .flag_wr_i(wr), .flag_wdata_i(wd),
      .flag_sof_o(f_sof), .flag_esof_o(f_esof), .flag_susp_o(f_susp),
      .flag_wkup_o(f_wkup), .wakeup_o(wake), .locked_o(lock)
   );

   task automatic chk(input string req, input logic act_v, input logic exp_v);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act_v, exp_v, $time);
      end
   endtask

   function automatic void model_step();
      logic esof, susp, wk;
      logic [3:0] setv, clr;
      esof = tick && !sof && !brst && (m_win == T-1);
      if (brst || sof || esof) m_win = 0;
      else if (tick) m_win = m_win + 1;
      susp = 1'b0;
      if (!(m_arm && !sact) || brst || sof || act) m_miss = 0;
      else if (esof) begin
         if (m_miss == M-1) begin susp = 1'b1; m_miss = 0; end
         else m_miss = m_miss + 1;
      end
      if (sact) m_arm = 1'b0;
      else if (brst || rdone) m_arm = 1'b1;
      if (sof) m_lock = 1'b1;
      wk = sact && act;
      setv = {wk, susp, esof, sof};
      clr = wr ? ~wd : 4'h0;
      m_flags = setv | (m_flags & ~clr);
      m_wake = wk;
   endfunction

   task automatic step();
      @(posedge clk);
      model_step();
      #1;
      chk("R2 sof flag", f_sof, m_flags[0]);
      chk("R3 esof flag", f_esof, m_flags[1]);
      chk("R6 susp flag", f_susp, m_flags[2]);
      chk("R9 wkup flag", f_wkup, m_flags[3]);
      chk("R9 wakeup strobe", wake, m_wake);
      chk("R2 locked", lock, m_lock);
      @(negedge clk);
      tick = 0; sof = 0; act = 0; brst = 0; rdone = 0; wr = 0; wd = 4'hF;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin tick = 1; step(); end
   endtask

   task automatic clear_all();
      wr = 1; wd = 4'h0; step();
   endtask

   initial begin
      m_win = 0; m_miss = 0; m_arm = 0; m_lock = 0; m_wake = 0; m_flags = 0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 reset sof", f_sof, 1'b0);
      chk("R1 reset esof", f_esof, 1'b0);
      chk("R1 reset susp", f_susp, 1'b0);
      chk("R1 reset wkup", f_wkup, 1'b0);
      chk("R1 reset wakeup", wake, 1'b0);
      chk("R1 reset locked", lock, 1'b0);
      @(negedge clk);

      // R5: unarmed after power reset, misses before lock still flag (R3)
      ticks(3*T);
      chk("R3 esof before lock", f_esof, 1'b1);
      chk("R5 no susp while unarmed", f_susp, 1'b0);

      // R10: write 1 keeps, write 0 clears
      sof = 1; step();
      wr = 1; wd = 4'b1101; step();
      chk("R10 esof cleared", f_esof, 1'b0);
      chk("R10 sof kept", f_sof, 1'b1);

      // R6: arm by bus reset, three misses
      clear_all();
      brst = 1; step();
      ticks(3*T - 1);
      chk("R6 no susp after two misses", f_susp, 1'b0);
      ticks(1);
      chk("R6 susp on third miss", f_susp, 1'b1);

      // R7: activity breaks the run
      clear_all();
      ticks(2*T);
      act = 1; step();
      ticks(2*T);
      chk("R7 run broken by activity", f_susp, 1'b0);
      ticks(T);
      chk("R7 third miss after activity", f_susp, 1'b1);

      // R4: SOF restarts the window
      clear_all();
      sof = 1; step();
      ticks(T-1);
      sof = 1; step();
      ticks(T-1);
      chk("R4 no esof inside window", f_esof, 1'b0);
      chk("R2 locked after sof", lock, 1'b1);
      ticks(1);
      chk("R3 esof at window end", f_esof, 1'b1);

      // R9 / R8: suspend, wakeup, rearm by resume
      clear_all();
      sact = 1; step();
      act = 1; step();
      chk("R9 wkup during suspend", f_wkup, 1'b1);
      chk("R9 wakeup strobe high", wake, 1'b1);
      step();
      chk("R9 wakeup strobe one cycle", wake, 1'b0);
      sact = 0; step();
      clear_all();
      ticks(3*T);
      chk("R8 check stays off after suspend", f_susp, 1'b0);
      rdone = 1; step();
      ticks(3*T);
      chk("R8 check rearmed by resume", f_susp, 1'b1);

      // R9 negative
      clear_all();
      act = 1; step();
      chk("R9 no wkup when awake", f_wkup, 1'b0);
      chk("R9 no strobe when awake", wake, 1'b0);

      // R11: set beats clear
      sof = 1; wr = 1; wd = 4'b1110; step();
      chk("R11 set wins over clear", f_sof, 1'b1);

      // random phase
      for (int c = 0; c < 4000; c++) begin
         tick  = ($urandom_range(0, 1) == 0);
         sof   = ($urandom_range(0, 15) == 0);
         act   = ($urandom_range(0, 19) == 0);
         brst  = ($urandom_range(0, 63) == 0);
         rdone = ($urandom_range(0, 39) == 0);
         if ($urandom_range(0, 49) == 0) sact = ~sact;
         wr    = ($urandom_range(0, 7) == 0);
         wd    = 4'($urandom_range(0, 15));
         step();
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule